// File: doc/BRIEF.md
# Floating-Point Exception and Special-Operand Controller

This block sits beside a floating-point arithmetic datapath and owns the control word and the sticky exception state. For every add, subtract, multiply or divide it looks only at the class of the two operands (NaN, infinite, zero, sign). When the result is fixed by the operands alone, it raises a bypass select and a code that names the fixed result. It also raises the invalid-operation or divide-by-zero flag where the operand pair calls for one. When no special rule applies, the bypass stays low and the datapath result is used.

The same block executes two commands. The clear command empties the exception flags. The initialise command also restores the default control word. A wait check compares the pending flags against the mask bits in the control word and drives a fault output in the same cycle. The datapath can report the flags it detects itself (denormal, overflow, underflow, precision, invalid) and stack faults through dedicated inputs, which are merged into the same sticky state. The two-bit rounding field of the control word is driven out for the datapath.

Top module: `fp_excp_ctrl`

## Requirements
- R1: After reset the control word reads 0x037F, the status word reads 0, the rounding mode output is 0, and neither bypass nor fault is asserted.
- R2: Operand class inputs are packed as bit0 NaN, bit1 infinite, bit2 zero, bit3 negative. Bypass codes are 0 none, 1 positive NaN, 2 negative NaN, 3 positive infinity and 4 negative infinity, and the bypass select is high exactly when the code is non-zero. An operation with a NaN operand returns code 1 and raises no flag.
- R3: Operations are encoded as 0 add, 1 subtract, 2 multiply, 3 divide. For an add with a single infinite operand, the result is that infinity. For an add of two infinities of equal sign, the result is that infinity. For two infinities of opposite sign, the invalid flag is raised and the result is a NaN carrying the sign of the first operand.
- R4: A subtract follows the add rules with the second operand's sign inverted. Two infinities of equal sign therefore raise invalid with a NaN of the first operand's sign, and an infinite second operand alone gives an infinity of the opposite sign.
- R5: A multiply of an infinity by a zero, in either order, raises invalid and returns code 2.
- R6: A divide of zero by zero raises invalid and returns a NaN with the dividend's sign. A divide of a non-zero dividend by zero raises divide-by-zero and returns an infinity with the dividend's sign.
- R7: An operation on finite, non-zero operands returns code 0 and raises nothing.
- R8: The status word holds invalid at bit 0, denormal at 1, divide-by-zero at 2, overflow at 3, underflow at 4, precision at 5 and stack fault at 6. Flags appear one cycle after they are raised, whether by a screened operation or by the datapath inputs, and stay set until a clear or an initialise.
- R9: The clear command zeroes bits 0 to 7 and bit 15 of the status word and leaves the control word unchanged.
- R10: The initialise command loads the control word with 0x037F and zeroes the status word, and it overrides a control word write in the same cycle.
- R11: A flag raised in the same cycle as a clear or an initialise is present after that command.
- R12: With the wait request high, the fault output is high in that cycle when any of status bits 0 to 5 is set while its mask (control word bits 0 to 5) is clear, or when stack fault is set while control bit 0 is clear.
- R13: Status bits 7 and 15 are both set exactly when the condition of R12, evaluated on the updated flags and control word, holds.
- R14: A control word write takes effect in the next cycle, and the rounding mode output equals control word bits 11:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An arithmetic operation is presented this cycle |
| op_sel | input | 2 | Operation: 0 add, 1 subtract, 2 multiply, 3 divide |
| a_class | input | 4 | First operand class {neg, zero, inf, nan} |
| b_class | input | 4 | Second operand class {neg, zero, inf, nan} |
| cmd_clear | input | 1 | Clear exception flags |
| cmd_init | input | 1 | Initialise control and status |
| wait_req | input | 1 | Evaluate pending unmasked exceptions |
| cw_wr | input | 1 | Write the control word |
| cw_wdata | input | 16 | New control word |
| dp_flags | input | 6 | Exception flags detected by the datapath |
| dp_stack_fault | input | 1 | Stack fault detected by the register stack |
| byp_sel | output | 1 | Use the bypass result instead of the datapath |
| byp_code | output | 3 | Fixed result code |
| status_word | output | 16 | Exception and summary flags |
| ctrl_word | output | 16 | Current control word |
| rnd_mode | output | 2 | Rounding field for the datapath |
| fault | output | 1 | Wait check found an unmasked exception |

## Verification
An exception raised by a screened operation can land in the same cycle as a clear or an initialise command. The initialise command can also meet a control word write in that cycle. The bench provokes both collisions on purpose: a divide-by-zero issued together with a clear, and an invalid add issued together with an initialise and a write of all-unmasked control bits. It then judges the next cycle's status and control words, and a following wait check, against a model in which the command acts first and the new flag is merged after it, and in which the initialise wins over the write.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NFLAG  = 6;
  localparam logic [WORD_W-1:0] CW_DEFAULT = 16'h037F;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } fop_e;

  typedef enum logic [2:0] {
    RC_NONE    = 3'd0,
    RC_NAN_POS = 3'd1,
    RC_NAN_NEG = 3'd2,
    RC_INF_POS = 3'd3,
    RC_INF_NEG = 3'd4
  } rcode_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic inf;
    logic nan;
  } oclass_t;

  localparam int unsigned F_IE = 0;
  localparam int unsigned F_ZE = 2;
endpackage

// File: rtl/fpx_screen.sv
`timescale 1ns/1ps
module fpx_screen
  import fpx_pkg::*;
(
  input  logic             valid_i,
  input  fop_e             op_i,
  input  oclass_t          a_i,
  input  oclass_t          b_i,
  output rcode_e           code_o,
  output logic [NFLAG-1:0] raise_o
);
  logic b_neg_eff;

  function automatic rcode_e nan_of(input logic s);
    return s ? RC_NAN_NEG : RC_NAN_POS;
  endfunction

  function automatic rcode_e inf_of(input logic s);
    return s ? RC_INF_NEG : RC_INF_POS;
  endfunction

  always_comb begin
    code_o    = RC_NONE;
    raise_o   = '0;
    b_neg_eff = b_i.neg ^ (op_i == OP_SUB);
    if (valid_i) begin
      if (a_i.nan || b_i.nan) begin
        code_o = RC_NAN_POS;
      end else begin
        unique case (op_i)
          OP_ADD, OP_SUB: begin
            if (a_i.inf && b_i.inf) begin
              if (a_i.neg == b_neg_eff) begin
                code_o = inf_of(a_i.neg);
              end else begin
                code_o        = nan_of(a_i.neg);
                raise_o[F_IE] = 1'b1;
              end
            end else if (a_i.inf) begin
              code_o = inf_of(a_i.neg);
            end else if (b_i.inf) begin
              code_o = inf_of(b_neg_eff);
            end
          end
          OP_MUL: begin
            if ((a_i.inf && b_i.zero) || (b_i.inf && a_i.zero)) begin
              code_o        = RC_NAN_NEG;
              raise_o[F_IE] = 1'b1;
            end
          end
          OP_DIV: begin
            if (b_i.zero) begin
              if (a_i.zero) begin
                code_o        = nan_of(a_i.neg);
                raise_o[F_IE] = 1'b1;
              end else begin
                code_o        = inf_of(a_i.neg);
                raise_o[F_ZE] = 1'b1;
              end
            end
          end
          default: code_o = RC_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpx_state.sv
`timescale 1ns/1ps
module fpx_state
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              init_i,
  input  logic              cw_wr_i,
  input  logic [WORD_W-1:0] cw_wdata_i,
  input  logic [NFLAG-1:0]  raise_i,
  input  logic              sf_i,
  output logic [WORD_W-1:0] cw_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic              sf_o,
  output logic              es_o
);
  logic [WORD_W-1:0] cw_q, cw_n;
  logic [NFLAG-1:0]  flags_q, flags_n;
  logic              sf_q, sf_n, es_q, es_n;
  logic              upd_en;

  always_comb begin
    cw_n    = cw_q;
    flags_n = flags_q;
    sf_n    = sf_q;
    if (init_i) begin
      cw_n    = CW_DEFAULT;
      flags_n = '0;
      sf_n    = 1'b0;
    end else begin
      if (cw_wr_i) cw_n = cw_wdata_i;
      if (clr_i) begin
        flags_n = '0;
        sf_n    = 1'b0;
      end
    end
    flags_n = flags_n | raise_i;
    sf_n    = sf_n | sf_i;
    es_n    = (|(flags_n & ~cw_n[NFLAG-1:0])) | (sf_n & ~cw_n[F_IE]);
    upd_en  = init_i | clr_i | cw_wr_i | (|raise_i) | sf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q    <= CW_DEFAULT;
      flags_q <= '0;
      sf_q    <= 1'b0;
      es_q    <= 1'b0;
    end else if (upd_en) begin
      cw_q    <= cw_n;
      flags_q <= flags_n;
      sf_q    <= sf_n;
      es_q    <= es_n;
    end
  end

  assign cw_o    = cw_q;
  assign flags_o = flags_q;
  assign sf_o    = sf_q;
  assign es_o    = es_q;

  // R8: a flag never drops without a clear or initialise
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_i) && !$past(init_i)) |->
      ((flags_q & $past(flags_q)) == $past(flags_q)) && ($past(sf_q) ? sf_q : 1'b1));

  // R9: a clear with nothing new raised leaves no flag behind
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_i) && ($past(raise_i) == '0) && !$past(sf_i)) |->
      (flags_q == '0) && !sf_q && !es_q);

  // R10: initialise restores the default control word
  p_init_cw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_i) |-> (cw_q == CW_DEFAULT));
endmodule

// File: rtl/fpx_wait.sv
`timescale 1ns/1ps
module fpx_wait
  import fpx_pkg::*;
(
  input  logic             req_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] masks_i,
  input  logic             sf_i,
  output logic             fault_o
);
  logic [NFLAG-1:0] pend;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_pend
    assign pend[gi] = flags_i[gi] & ~masks_i[gi];
  end

  assign fault_o = req_i & ((|pend) | (sf_i & ~masks_i[F_IE]));
endmodule

// File: rtl/fp_excp_ctrl.sv
`timescale 1ns/1ps
module fp_excp_ctrl
  import fpx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op_sel,
  input  logic [3:0]  a_class,
  input  logic [3:0]  b_class,
  input  logic        cmd_clear,
  input  logic        cmd_init,
  input  logic        wait_req,
  input  logic        cw_wr,
  input  logic [15:0] cw_wdata,
  input  logic [5:0]  dp_flags,
  input  logic        dp_stack_fault,
  output logic        byp_sel,
  output logic [2:0]  byp_code,
  output logic [15:0] status_word,
  output logic [15:0] ctrl_word,
  output logic [1:0]  rnd_mode,
  output logic        fault
);
  rcode_e           scr_code;
  logic [NFLAG-1:0] scr_raise;
  logic [NFLAG-1:0] flags;
  logic             sf, es;
  logic [WORD_W-1:0] cw;

  fpx_screen u_screen (
    .valid_i (op_valid),
    .op_i    (fop_e'(op_sel)),
    .a_i     (oclass_t'(a_class)),
    .b_i     (oclass_t'(b_class)),
    .code_o  (scr_code),
    .raise_o (scr_raise)
  );

  fpx_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cmd_clear),
    .init_i     (cmd_init),
    .cw_wr_i    (cw_wr),
    .cw_wdata_i (cw_wdata),
    .raise_i    (scr_raise | dp_flags),
    .sf_i       (dp_stack_fault),
    .cw_o       (cw),
    .flags_o    (flags),
    .sf_o       (sf),
    .es_o       (es)
  );

  fpx_wait u_wait (
    .req_i   (wait_req),
    .flags_i (flags),
    .masks_i (cw[NFLAG-1:0]),
    .sf_i    (sf),
    .fault_o (fault)
  );

  assign byp_code    = scr_code;
  assign byp_sel     = (scr_code != RC_NONE);
  assign status_word = {es, 7'd0, es, sf, flags};
  assign ctrl_word   = cw;
  assign rnd_mode    = cw[11:10];

  // R2: any NaN operand yields the positive NaN code
  p_nan_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (a_class[0] || b_class[0])) |-> (byp_code == 3'd1));

  // R6: non-zero over zero leaves divide-by-zero pending next cycle
  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 2'd3 && b_class[2] && !a_class[2] &&
     !a_class[0] && !b_class[0]) |=> status_word[2]);

  // R12: with every mask set the wait check stays quiet
  p_masked_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && ctrl_word[5:0] == 6'h3F) |-> !fault);
endmodule

// File: tb/sim_fp_excp_ctrl.sv
`timescale 1ns/1ps
module sim_fp_excp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_sel;
  logic [3:0]  a_class, b_class;
  logic        cmd_clear, cmd_init, wait_req, cw_wr;
  logic [15:0] cw_wdata;
  logic [5:0]  dp_flags;
  logic        dp_stack_fault;
  logic        byp_sel;
  logic [2:0]  byp_code;
  logic [15:0] status_word, ctrl_word;
  logic [1:0]  rnd_mode;
  logic        fault;

  always #2 clk = ~clk;

  fp_excp_ctrl u0 (.*);

  // class encodings {neg, zero, inf, nan}
  localparam logic [3:0] C_FIN  = 4'b0000;
  localparam logic [3:0] C_NAN  = 4'b0001;
  localparam logic [3:0] C_PINF = 4'b0010;
  localparam logic [3:0] C_NINF = 4'b1010;
  localparam logic [3:0] C_PZ   = 4'b0100;
  localparam logic [3:0] C_NZ   = 4'b1100;
  localparam logic [3:0] C_NFIN = 4'b1000;

  typedef struct {
    logic [2:0]  code;
    logic        flt;
    logic [15:0] sw;
    logic [15:0] cw;
    string       rq;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [5:0]  m_f;
  logic        m_sf;
  logic [15:0] m_cw;

  task automatic chk(string rq, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
    op_valid = 0; op_sel = 0; a_class = C_FIN; b_class = C_FIN;
    cmd_clear = 0; cmd_init = 0; wait_req = 0; cw_wr = 0; cw_wdata = 0;
    dp_flags = 0; dp_stack_fault = 0;
  endtask

  // reference model: command first, new flags merged after
  task automatic push(logic [2:0] code, logic [5:0] raise, string rq);
    item_t it;
    logic es;
    it.flt = wait_req && ((|(m_f & ~m_cw[5:0])) || (m_sf && !m_cw[0]));
    if (cmd_init) begin
      m_cw = 16'h037F; m_f = 0; m_sf = 0;
    end else begin
      if (cw_wr) m_cw = cw_wdata;
      if (cmd_clear) begin m_f = 0; m_sf = 0; end
    end
    m_f  = m_f | raise | dp_flags;
    m_sf = m_sf | dp_stack_fault;
    es   = (|(m_f & ~m_cw[5:0])) || (m_sf && !m_cw[0]);
    it.code = code;
    it.sw   = {es, 7'd0, es, m_sf, m_f};
    it.cw   = m_cw;
    it.rq   = rq;
    q.push_back(it);
  endtask

  task automatic op(logic [1:0] o, logic [3:0] a, logic [3:0] b,
                    logic [2:0] code, logic [5:0] raise, string rq);
    op_valid = 1; op_sel = o; a_class = a; b_class = b;
    push(code, raise, rq);
  endtask

  // monitor: compare combinational outputs mid-cycle, registered after the edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.rq, "byp_code", {13'd0, byp_code}, {13'd0, it.code});
        chk(it.rq, "byp_sel", {15'd0, byp_sel}, {15'd0, it.code != 3'd0});
        chk(it.rq, "fault", {15'd0, fault}, {15'd0, it.flt});
        #2;
        chk(it.rq, "status_word", status_word, it.sw);
        chk(it.rq, "ctrl_word", ctrl_word, it.cw);
        chk(it.rq, "rnd_mode", {14'd0, rnd_mode}, {14'd0, it.cw[11:10]});
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    op_valid = 0; op_sel = 0; a_class = 0; b_class = 0;
    cmd_clear = 0; cmd_init = 0; wait_req = 0; cw_wr = 0; cw_wdata = 0;
    dp_flags = 0; dp_stack_fault = 0;
    m_f = 0; m_sf = 0; m_cw = 16'h037F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1", "reset status", status_word, 16'h0000);
    chk("R1", "reset control", ctrl_word, 16'h037F);
    chk("R1", "reset rnd", {14'd0, rnd_mode}, 16'd0);
    chk("R1", "reset bypass", {15'd0, byp_sel}, 16'd0);
    chk("R1", "reset fault", {15'd0, fault}, 16'd0);

    cyc; op(2'd0, C_FIN, C_NFIN, 3'd0, 6'd0, "R7");
    cyc; op(2'd3, C_FIN, C_NFIN, 3'd0, 6'd0, "R7");
    cyc; op(2'd0, C_NAN, C_PINF, 3'd1, 6'd0, "R2");
    cyc; op(2'd3, C_PZ, C_NAN, 3'd1, 6'd0, "R2");
    cyc; op(2'd0, C_PINF, C_NFIN, 3'd3, 6'd0, "R3");
    cyc; op(2'd0, C_FIN, C_NINF, 3'd4, 6'd0, "R3");
    cyc; op(2'd0, C_NINF, C_NINF, 3'd4, 6'd0, "R3");
    cyc; op(2'd0, C_NINF, C_PINF, 3'd2, 6'd1, "R3");
    cyc; op(2'd1, C_PINF, C_PINF, 3'd1, 6'd1, "R4");
    cyc; op(2'd1, C_FIN, C_PINF, 3'd4, 6'd0, "R4");
    cyc; op(2'd1, C_PINF, C_NINF, 3'd3, 6'd0, "R4");
    cyc; op(2'd2, C_PINF, C_PZ, 3'd2, 6'd1, "R5");
    cyc; op(2'd2, C_NZ, C_NINF, 3'd2, 6'd1, "R5");
    cyc; op(2'd3, C_NZ, C_PZ, 3'd2, 6'd1, "R6");
    cyc; op(2'd3, C_FIN, C_PZ, 3'd3, 6'd4, "R6");
    cyc; op(2'd3, C_NINF, C_NZ, 3'd4, 6'd4, "R6");
    cyc; push(3'd0, 6'd0, "R8");
    cyc; dp_flags = 6'b010000; push(3'd0, 6'd0, "R8");
    cyc; dp_stack_fault = 1; push(3'd0, 6'd0, "R8");
    cyc; wait_req = 1; push(3'd0, 6'd0, "R12");
    cyc; cw_wr = 1; cw_wdata = 16'h0C40; push(3'd0, 6'd0, "R14");
    cyc; push(3'd0, 6'd0, "R13");
    cyc; wait_req = 1; push(3'd0, 6'd0, "R12");
    cyc; cmd_clear = 1; push(3'd0, 6'd0, "R9");
    cyc; wait_req = 1; push(3'd0, 6'd0, "R12");
    cyc; dp_stack_fault = 1; push(3'd0, 6'd0, "R8");
    cyc; wait_req = 1; push(3'd0, 6'd0, "R12");
    cyc; cmd_clear = 1; push(3'd0, 6'd0, "R9");
    cyc; dp_stack_fault = 1; cw_wr = 1; cw_wdata = 16'h0001; push(3'd0, 6'd0, "R14");
    cyc; wait_req = 1; push(3'd0, 6'd0, "R12");
    cyc; cmd_clear = 1; op(2'd3, C_NFIN, C_PZ, 3'd4, 6'd4, "R11");
    cyc; wait_req = 1; push(3'd0, 6'd0, "R12");
    cyc; cmd_init = 1; cw_wr = 1; cw_wdata = 16'h0000;
         op(2'd0, C_PINF, C_NINF, 3'd1, 6'd1, "R11");
    cyc; wait_req = 1; push(3'd0, 6'd0, "R10");
    cyc; cmd_init = 1; push(3'd0, 6'd0, "R10");
    cyc; op(2'd0, C_FIN, C_FIN, 3'd0, 6'd0, "R7");
    cyc;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule